// File: doc/BRIEF.md
# Periodic Reload Countdown Timer

This block is a 16-bit down-counter that sits on a simple word-wide register bus. Software programs a reload value, then sets a start bit. From then on the counter steps down once per microsecond. When it is at zero and a tick arrives, it takes the reload value again and raises a one-cycle expiry pulse. The result is a steady periodic event. A free-running prescaler produces the microsecond tick from the system clock. The division ratio is derived from two parameters: the system clock rate and the tick rate.

The bus side has three registers: control, reload and live count. They are decoded inside a 256-byte window, and only whole, word-aligned 32-bit accesses are used. The register offsets are 0x00 for control, 0x08 for reload and 0x0C for count. In control, bit 0 is the self-clearing software reset and bit 1 is the start bit. Reads are combinational from the address. A write takes effect at the clock edge on which `bus_we` is high.

A two-state machine governs counting. HALT is entered on hardware reset and on the SOFT_RESET transition. RUN is entered from HALT on the START transition, which is a control write with bit 1 set and bit 0 clear. In RUN, a control write with bit 1 clear is a STAY transition, so the counter keeps running. Only SOFT_RESET leaves RUN, returning to HALT.

Top module: `reload_tick_timer`

## Requirements
- R1: After hardware reset the state is HALT. Control, reload and count all read zero, `expire_o` is low, and the count does not move until a start.
- R2: A control write with bit 0 set clears control, reload and count to zero and moves to HALT, whatever the other bits are. The written word is not stored, and later reload writes do not make the count move.
- R3: A control write with bit 0 clear stores all 32 bits in the control register. If bit 1 is also set, counting starts.
- R4: While counting, a control write with bit 1 clear updates the stored word but does not stop the counter.
- R5: A write to offset 0x08 keeps bits 15:0 of the write data, which then read back zero-extended. The same write loads the count with that value on the same edge.
- R6: A read of offset 0x0C returns the live count in bits 15:0 with bits 31:16 zero. Writes to 0x0C change nothing.
- R7: In RUN the count drops by one on each tick. A tick occurs once every CLK_HZ/TICK_HZ clocks (250 clocks by default), counted from the release of reset.
- R8: A tick that finds the count at zero in RUN does one of two things. If reload is nonzero, the count is reloaded and `expire_o` is high for exactly one cycle, so pulses are (reload+1) ticks apart. If reload is zero, the count holds at zero and no pulse is raised.
- R9: Offsets other than 0x00, 0x08 and 0x0C read zero, and writes to them change nothing. This includes offsets that are not word-aligned.
- R10: If a reload write and a tick fall on the same edge, the written value wins. A software reset overrides any tick on its edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_we | input | 1 | Write strobe, one word per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| expire_o | output | 1 | One-cycle pulse on each wrap-around reload |

## Verification
A wrong count or reload register shows up at the next read of 0x0C or 0x08. It also shows up as an expiry pulse early, late or missing, within one reload period. A state machine stuck in RUN would let the count drift after a software reset. One stuck in HALT would freeze the count; a count frozen through more than one tick period exposes either fault. A mis-phased prescaler moves every count change and every expiry pulse off the expected cycle. The per-cycle comparison catches this within one tick period.

// File: rtl/rtt_pkg.sv
`timescale 1ns/1ps
package rtt_pkg;
    localparam int ADDR_W = 8;
    localparam int BUS_W  = 32;
    localparam int CNT_W  = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h0C;

    localparam int BIT_SRST = 0;
    localparam int BIT_GO   = 1;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef struct packed {
        logic             srst;
        logic             go;
        logic             reload_wr;
        logic [CNT_W-1:0] reload_val;
    } bus_cmd_t;
endpackage

// File: rtl/rtt_prescaler.sv
`timescale 1ns/1ps
module rtt_prescaler #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtt_regfile.sv
`timescale 1ns/1ps
module rtt_regfile
    import rtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  count,
    output bus_cmd_t          cmd,
    output logic [CNT_W-1:0]  reload_q,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int PAD_W = BUS_W - CNT_W;

    logic             ctrl_wr;
    logic [BUS_W-1:0] ctrl_q;

    assign ctrl_wr        = bus_we && (bus_addr == OFS_CTRL);
    assign cmd.srst       = ctrl_wr && bus_wdata[BIT_SRST];
    assign cmd.go         = ctrl_wr && !bus_wdata[BIT_SRST] && bus_wdata[BIT_GO];
    assign cmd.reload_wr  = bus_we && (bus_addr == OFS_RELOAD);
    assign cmd.reload_val = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cmd.srst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (cmd.srst) begin
            reload_q <= '0;
        end else if (cmd.reload_wr) begin
            reload_q <= cmd.reload_val;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_RELOAD: bus_rdata = {{PAD_W{1'b0}}, reload_q};
            OFS_COUNT:  bus_rdata = {{PAD_W{1'b0}}, count};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtt_core.sv
`timescale 1ns/1ps
module rtt_core
    import rtt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  bus_cmd_t         cmd,
    input  logic [CNT_W-1:0] reload_q,
    output run_state_t       state_q,
    output logic [CNT_W-1:0] count_q,
    output logic             expire_q
);
    run_state_t       state_d;
    logic [CNT_W-1:0] count_d;
    logic             expire_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (cmd.go)   state_d = ST_RUN;
            ST_RUN:  if (cmd.srst) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        count_d  = count_q;
        expire_d = 1'b0;
        if (cmd.srst) begin
            count_d = '0;
        end else if (cmd.reload_wr) begin
            count_d = cmd.reload_val;
        end else if ((state_q == ST_RUN) && tick) begin
            if (count_q != '0) begin
                count_d = count_q - 1'b1;
            end else if (reload_q != '0) begin
                count_d  = reload_q;
                expire_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            expire_q <= 1'b0;
        end else begin
            count_q  <= count_d;
            expire_q <= expire_d;
        end
    end
endmodule

// File: rtl/reload_tick_timer.sv
`timescale 1ns/1ps
module reload_tick_timer
    import rtt_pkg::*;
#(
    parameter int CLK_HZ  = 250_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              expire_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic             tick;
    bus_cmd_t         cmd;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    run_state_t       run_state;

    rtt_prescaler #(.DIV(DIV)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    rtt_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .count    (count_q),
        .cmd      (cmd),
        .reload_q (reload_q),
        .bus_rdata(bus_rdata)
    );

    rtt_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cmd     (cmd),
        .reload_q(reload_q),
        .state_q (run_state),
        .count_q (count_q),
        .expire_q(expire_o)
    );
endmodule

// File: rtl/rtt_checker.sv
`timescale 1ns/1ps
module rtt_checker
    import rtt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input run_state_t        state,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload,
    input logic              expire,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata
);
    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8
    expire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R8
    expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (count == reload && reload != '0 && $past(count) == '0));

    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(bus_we && bus_addr == OFS_CTRL && bus_wdata[BIT_SRST]))
        |=> state == ST_RUN);

    // R2
    halt_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !bus_we) |=> $stable(count));

    // R6
    count_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_COUNT) |-> (bus_rdata[BUS_W-1:CNT_W] == '0));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_CTRL && bus_addr != OFS_RELOAD && bus_addr != OFS_COUNT)
        |-> bus_rdata == '0);
endmodule

bind reload_tick_timer rtt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .state    (run_state),
    .count    (count_q),
    .reload   (reload_q),
    .expire   (expire_o),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
);

// File: tb/reload_tick_timer_test.sv
`timescale 1ns/1ps
module reload_tick_timer_test;
    localparam int DIV = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        expire_o;

    int n_chk = 0;
    int n_bad = 0;
    bit live = 1'b0;

    // behavioural reference state
    logic [31:0] m_ctrl = '0;
    int          m_rel = 0;
    int          m_cnt = 0;
    bit          m_run = 1'b0;
    int          m_phase = 0;
    bit          m_exp = 1'b0;

    always #2 clk = ~clk;

    reload_tick_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .expire_o (expire_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_rel = 0; m_cnt = 0; m_run = 0; m_phase = 0; m_exp = 0;
        end else begin
            bit tk;
            bit was_run;
            tk = (m_phase == DIV - 1);
            m_phase = tk ? 0 : m_phase + 1;
            was_run = m_run;
            m_exp = 0;
            if (bus_we && bus_addr == 8'h00 && bus_wdata[0]) begin
                m_ctrl = '0; m_rel = 0; m_cnt = 0; m_run = 0;
            end else begin
                if (bus_we && bus_addr == 8'h00) begin
                    m_ctrl = bus_wdata;
                    if (bus_wdata[1]) m_run = 1;
                end
                if (bus_we && bus_addr == 8'h08) begin
                    m_rel = int'(bus_wdata[15:0]);
                    m_cnt = m_rel;
                end else if (was_run && tk) begin
                    if (m_cnt != 0) m_cnt = m_cnt - 1;
                    else if (m_rel != 0) begin m_cnt = m_rel; m_exp = 1; end
                end
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        case (a)
            8'h00:   return m_ctrl;
            8'h08:   return 32'(m_rel);
            8'h0C:   return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (live && rst_n) begin
            case (bus_addr)
                8'h00:   chk("R3 ctrl cycle", bus_rdata, model_rd(bus_addr));
                8'h08:   chk("R5 reload cycle", bus_rdata, model_rd(bus_addr));
                8'h0C:   chk("R7 count cycle", bus_rdata, model_rd(bus_addr));
                default: chk("R9 unmapped cycle", bus_rdata, model_rd(bus_addr));
            endcase
            chk("R8 expire cycle", {31'b0, expire_o}, {31'b0, m_exp});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] c1;
        int gap;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;

        // R1 reset values
        rd(8'h00, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(8'h08, v); chk("R1 reload after reset", v, 32'h0);
        rd(8'h0C, v); chk("R1 count after reset", v, 32'h0);
        chk("R1 expire after reset", {31'b0, expire_o}, 32'h0);

        // R5 reload write also loads count
        wr(8'h08, 32'h1234_0005);
        rd(8'h08, v); chk("R5 reload low half kept", v, 32'h5);
        rd(8'h0C, v); chk("R5 count loaded", v, 32'h5);
        idle(600);
        rd(8'h0C, v); chk("R1 no counting before start", v, 32'h5);

        // R3 start keeps full word
        wr(8'h00, 32'hABCD_0002);
        rd(8'h00, v); chk("R3 ctrl full word", v, 32'hABCD_0002);
        idle(300);
        rd(8'h0C, v); chk("R3 counting after start", {31'b0, v < 32'h5}, 32'h1);

        // R8 / R7 period between expiry pulses
        gap = 0;
        while (!expire_o && gap < 4000) begin @(negedge clk); gap++; end
        chk("R8 first expire seen", {31'b0, expire_o}, 32'h1);
        gap = 0;
        @(negedge clk); gap++;
        while (!expire_o && gap < 4000) begin @(negedge clk); gap++; end
        chk("R7 R8 pulse spacing", 32'(gap), 32'((5 + 1) * DIV));
        rd(8'h0C, v); chk("R8 count reloaded", v, 32'h5);

        // R4 clearing enable does not stop
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, v); chk("R4 ctrl updated", v, 32'h0);
        rd(8'h0C, c1);
        idle(500);
        rd(8'h0C, v); chk("R4 still counting", {31'b0, v != c1}, 32'h1);

        // R6 count writes ignored
        wr(8'h0C, 32'hFFFF_7777);
        rd(8'h0C, v);
        chk("R6 count write ignored", v, 32'(m_cnt));
        chk("R6 upper bits zero", {16'h0, v[31:16]}, 32'h0);

        // R9 unmapped and misaligned
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h09, 32'h0000_0077);
        wr(8'h10, 32'h1111_2222);
        wr(8'h01, 32'h0000_0001);
        rd(8'h04, v); chk("R9 read 0x04", v, 32'h0);
        rd(8'h10, v); chk("R9 read 0x10", v, 32'h0);
        rd(8'h09, v); chk("R9 read 0x09", v, 32'h0);
        rd(8'h08, v); chk("R9 reload untouched", v, 32'h5);
        rd(8'h00, v); chk("R9 ctrl untouched", v, 32'h0);
        rd(8'h0C, c1);
        idle(300);
        rd(8'h0C, v); chk("R9 misaligned reset ignored", {31'b0, v != c1}, 32'h1);

        // R10 reload write on the tick edge
        @(posedge clk); #1;
        while (m_phase != DIV - 1) begin @(posedge clk); #1; end
        bus_addr = 8'h08; bus_we = 1'b1; bus_wdata = 32'h0000_0009;
        @(posedge clk); #1;
        bus_we = 1'b0;
        rd(8'h0C, v); chk("R10 write beats tick", v, 32'h9);

        // R8 zero reload holds without pulses
        wr(8'h08, 32'h0);
        pulses = 0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (expire_o) pulses++;
        end
        chk("R8 zero reload no pulse", 32'(pulses), 32'h0);
        rd(8'h0C, v); chk("R8 zero reload holds", v, 32'h0);

        // R2 software reset
        wr(8'h08, 32'h7);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 ctrl cleared", v, 32'h0);
        rd(8'h08, v); chk("R2 reload cleared", v, 32'h0);
        rd(8'h0C, v); chk("R2 count cleared", v, 32'h0);
        wr(8'h08, 32'h3);
        idle(1000);
        rd(8'h0C, v); chk("R2 stopped after reset", v, 32'h3);
        wr(8'h00, 32'h2);
        idle(600);
        rd(8'h0C, v); chk("R3 restart counts", {31'b0, v < 32'h3}, 32'h1);

        live = 1'b0;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired got=hang exp=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule